// File: doc/BRIEF.md
# Byte-Program Sequencer for a Nonvolatile Array

This block sits between a CPU-side byte bus and a nonvolatile memory array. It controls how single bytes of the array are programmed. Software first turns on capture through a control register. The next write to a programmable array address is then held in an address/data latch and does not reach the cells. Software then raises the program bit, which drives the high-voltage enable. Software clears that bit again, or an internal timer clears it in self-timed mode. On the cycle the bit drops, the sequencer strobes the array. The new cell value is the old value ANDed with the latched data, because an erased cell reads 1 and programming can only pull bits to 0.

The sequencer is a four-state machine:
- IDLE: capture off.
- LATCH: capture on, nothing captured yet.
- HELD: a valid write has been captured.
- PROG: the program bit is set.

The transitions are:
- IDLE to LATCH: a control write with the capture bit set.
- LATCH to HELD: a valid array write.
- HELD to PROG: an accepted program request.
- HELD to IDLE: a control write with the capture bit clear.
- PROG to HELD: the program bit clears, by software or by the self-timer.

Reading an array location while capture is on returns the latched byte and moves the latched address to the read address. Any array read during PROG spoils the cycle. A manual cycle ended too early is also spoiled. A spoiled cycle writes nothing and sets a sticky fail flag.

Top module: `nvm_byte_prog_seq`

## Requirements
- R1: After reset, hv_en and prog_fail are 0 and the control register (at CTL_ADDR) reads 0x00. Its fields are: bit0 program, bit1 capture, bits 3:2 erase select, bit4 self-timed, bit7 fail (read-only, sticky).
- R2: With capture off (IDLE), array writes leave the array unchanged. A control write with bit1 set enters LATCH.
- R3: An address is valid if it is the config location CFG_ADDR, or if it lies inside the array and its block is not protected. The block index is offset/(ARR_BYTES/NBLK), and blk_prot[i] protects block i. Only valid writes are captured, and the last captured write replaces earlier ones.
- R4: While capture is on (LATCH or HELD), an array read returns the latched data and makes the read address the new latched address.
- R5: In LATCH, before any valid write is captured, control writes are ignored.
- R6: A control write with bit0 set starts programming only if all of these hold: the state is HELD, the latched address is valid, and the written bits 3:2 are 00. Otherwise the request is ignored.
- R7: hv_en is high exactly while the program bit is set. On the cycle the bit clears, arr_we pulses with arr_wdata = old byte AND latched data, written at the latched address.
- R8: With bit4 set, the program bit clears itself after exactly T_AUTO cycles.
- R9: A control write that clears bit0 and bit1 together during PROG clears only bit0. The control register then reads with bit1 still set.
- R10: An array read during PROG cancels the write-back and sets prog_fail, which stays set until reset.
- R11: Clearing bit0 by software before it has been high for T_PGM cycles cancels the write-back and sets prog_fail.
- R12: From HELD, a control write with bit1 clear returns to IDLE, where array reads return the array contents directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data (combinational) |
| blk_prot | input | NBLK | Per-block protect flags |
| arr_addr | output | ADDR_W | Array address |
| arr_rdata | input | DATA_W | Array read data |
| arr_wdata | output | DATA_W | Array program data |
| arr_we | output | 1 | Array program strobe |
| hv_en | output | 1 | High-voltage enable |
| prog_fail | output | 1 | Sticky spoiled-cycle flag |

## Verification
Some properties are checked on every cycle:
- The array strobe appears only inside a high-voltage window, and only for a valid latched address.
- Every rise of hv_en follows a control write that asked for programming.
- A self-timed window never outlasts T_AUTO.
- Capture is still on when hv_en falls.
- The fail flag never drops.

Other behaviours only the bench scenarios can show:
- The AND write-back value.
- Last-write-wins capture.
- Relatching on reads.
- Control writes ignored before the first capture.
- Refusal of program requests with erase bits set or a protected latched address.
- Both failure causes.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_LATCH,
        S_HELD,
        S_PROG
    } seq_state_e;

    localparam int B_ARM  = 0;
    localparam int B_CAP  = 1;
    localparam int B_ERS0 = 2;
    localparam int B_ERS1 = 3;
    localparam int B_AUTO = 4;
    localparam int B_FAIL = 7;
endpackage

// File: rtl/nvm_addr_decode.sv
module nvm_addr_decode #(
    parameter int ADDR_W    = 8,
    parameter int ARR_BASE  = 0,
    parameter int ARR_BYTES = 64,
    parameter int NBLK      = 4,
    parameter int CFG_ADDR  = 'h60
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBLK-1:0]   prot,
    output logic              in_rng,
    output logic              ok
);
    localparam int BLK_BYTES = ARR_BYTES / NBLK;

    logic            in_arr;
    logic            cfg_hit;
    logic [NBLK-1:0] blk_hit;
    int              off;

    always_comb begin
        off     = int'(addr) - ARR_BASE;
        in_arr  = (int'(addr) >= ARR_BASE) && (int'(addr) < ARR_BASE + ARR_BYTES);
        cfg_hit = (addr == ADDR_W'(CFG_ADDR));
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        assign blk_hit[g] = in_arr && (off >= g * BLK_BYTES) && (off < (g + 1) * BLK_BYTES);
    end

    assign in_rng = in_arr | cfg_hit;
    assign ok     = cfg_hit | (|(blk_hit & ~prot));
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != {CW{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nvm_byte_prog_seq.sv
module nvm_byte_prog_seq
    import nvm_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ARR_BASE  = 0,
    parameter int ARR_BYTES = 64,
    parameter int NBLK      = 4,
    parameter int CFG_ADDR  = 'h60,
    parameter int CTL_ADDR  = 'h70,
    parameter int T_PGM     = 64,
    parameter int T_AUTO    = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [NBLK-1:0]   blk_prot,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_we,
    output logic              hv_en,
    output logic              prog_fail
);
    localparam int              CW        = $clog2(T_PGM + 1) + 1;
    localparam logic [CW-1:0]   AUTO_LAST = CW'(T_AUTO - 1);
    localparam logic [CW-1:0]   PGM_LAST  = CW'(T_PGM - 1);

    seq_state_e          state_q, state_d;
    logic                auto_q;
    logic [1:0]          ers_q;
    logic                fail_q;
    logic                abort_q;
    logic [ADDR_W-1:0]   lat_addr_q;
    logic [DATA_W-1:0]   lat_data_q;
    logic [CW-1:0]       cnt;

    logic cur_in, cur_ok, lat_in, lat_ok;
    logic ctl_wr, ctl_rd, arr_wr_ok, arr_rd;
    logic arm_req, auto_done, sw_clr, fin, short_pulse, bad_now;
    logic cap_on, in_prog;
    logic [DATA_W-1:0] ctl_byte;

    nvm_addr_decode #(
        .ADDR_W(ADDR_W), .ARR_BASE(ARR_BASE), .ARR_BYTES(ARR_BYTES),
        .NBLK(NBLK), .CFG_ADDR(CFG_ADDR)
    ) u_dec_cpu (
        .addr(cpu_addr), .prot(blk_prot), .in_rng(cur_in), .ok(cur_ok)
    );

    nvm_addr_decode #(
        .ADDR_W(ADDR_W), .ARR_BASE(ARR_BASE), .ARR_BYTES(ARR_BYTES),
        .NBLK(NBLK), .CFG_ADDR(CFG_ADDR)
    ) u_dec_lat (
        .addr(lat_addr_q), .prot(blk_prot), .in_rng(lat_in), .ok(lat_ok)
    );

    nvm_prog_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(in_prog), .cnt(cnt)
    );

    // request decode
    always_comb begin
        cap_on      = (state_q != S_IDLE);
        in_prog     = (state_q == S_PROG);
        ctl_wr      = cpu_wr && (cpu_addr == ADDR_W'(CTL_ADDR));
        ctl_rd      = cpu_rd && (cpu_addr == ADDR_W'(CTL_ADDR));
        arr_wr_ok   = cpu_wr && cur_ok;
        arr_rd      = cpu_rd && cur_in;
        arm_req     = ctl_wr && cpu_wdata[B_ARM] && (cpu_wdata[B_ERS1:B_ERS0] == 2'b00)
                      && lat_ok && lat_in;
        auto_done   = in_prog && auto_q && (cnt == AUTO_LAST);
        sw_clr      = in_prog && ctl_wr && !cpu_wdata[B_ARM];
        fin         = auto_done || sw_clr;
        short_pulse = sw_clr && !auto_done && (cnt < (auto_q ? AUTO_LAST : PGM_LAST));
        bad_now     = abort_q || arr_rd || short_pulse;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ctl_wr && cpu_wdata[B_CAP]) state_d = S_LATCH;
            S_LATCH: if (arr_wr_ok) state_d = S_HELD;
            S_HELD: begin
                if (arm_req)
                    state_d = S_PROG;
                else if (ctl_wr && !cpu_wdata[B_CAP])
                    state_d = S_IDLE;
            end
            S_PROG:  if (fin) state_d = S_HELD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // control fields, latch and failure tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q     <= 1'b0;
            ers_q      <= 2'b00;
            fail_q     <= 1'b0;
            abort_q    <= 1'b0;
            lat_addr_q <= '0;
            lat_data_q <= '1;
        end else begin
            if (ctl_wr && (state_q == S_IDLE || state_q == S_HELD)) begin
                auto_q <= cpu_wdata[B_AUTO];
                ers_q  <= cpu_wdata[B_ERS1:B_ERS0];
            end
            if (state_q == S_LATCH || state_q == S_HELD) begin
                if (arr_wr_ok) begin
                    lat_addr_q <= cpu_addr;
                    lat_data_q <= cpu_wdata;
                end else if (arr_rd) begin
                    lat_addr_q <= cpu_addr;
                end
            end
            if (!in_prog)
                abort_q <= 1'b0;
            else if (arr_rd)
                abort_q <= 1'b1;
            if (fin && bad_now)
                fail_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ctl_byte                    = '0;
        ctl_byte[B_ARM]             = in_prog;
        ctl_byte[B_CAP]             = cap_on;
        ctl_byte[B_ERS1:B_ERS0]     = ers_q;
        ctl_byte[B_AUTO]            = auto_q;
        ctl_byte[B_FAIL]            = fail_q;

        hv_en     = in_prog;
        prog_fail = fail_q;
        arr_we    = fin && !bad_now;
        arr_addr  = cap_on ? lat_addr_q : cpu_addr;
        arr_wdata = arr_rdata & lat_data_q;
        if (ctl_rd)
            cpu_rdata = ctl_byte;
        else if (cur_in)
            cpu_rdata = cap_on ? lat_data_q : arr_rdata;
        else
            cpu_rdata = '0;
    end
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int CTL_ADDR = 'h70,
    parameter int T_AUTO   = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_en,
    input logic              arr_we,
    input logic              prog_fail,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              lat_ok,
    input logic              cap_on,
    input logic              auto_on
);
    int hv_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hv_run <= 0;
        else if (!hv_en) hv_run <= 0;
        else             hv_run <= hv_run + 1;
    end

    // R7
    we_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> hv_en);

    // R7
    we_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !hv_en);

    // R6
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> $past(cpu_wr && cpu_addr == ADDR_W'(CTL_ADDR) && cpu_wdata[0]));

    // R3
    prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> lat_ok);

    // R8
    auto_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en && auto_on) |-> (hv_run < T_AUTO));

    // R9
    staged_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hv_en) |-> cap_on);

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fail |=> prog_fail);
endmodule

bind nvm_byte_prog_seq nvm_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR), .T_AUTO(T_AUTO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .arr_we(arr_we),
    .prog_fail(prog_fail), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .lat_ok(lat_ok), .cap_on(cap_on), .auto_on(auto_q)
);

// File: tb/nvm_byte_prog_seq_bench.sv
`timescale 1ns/1ps
module nvm_byte_prog_seq_bench;
    localparam logic [7:0] CTL = 8'h70;
    localparam logic [7:0] CFG = 8'h60;
    localparam int TP = 64;
    localparam int TA = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [3:0] blk_prot = 4'b0010;
    logic [7:0] arr_addr, arr_rdata, arr_wdata;
    logic       arr_we, hv_en, prog_fail;

    logic [7:0] mem   [0:255];
    logic [7:0] m_mem [0:255];

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    nvm_byte_prog_seq u_nvm_byte_prog_seq (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .blk_prot(blk_prot), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .arr_wdata(arr_wdata), .arr_we(arr_we), .hv_en(hv_en), .prog_fail(prog_fail)
    );

    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;

    // behavioural reference model
    int         m_mode = 0;   // 0 off, 1 waiting, 2 captured, 3 programming
    int         m_len = 0;
    bit         m_bad = 0, m_fail = 0, m_auto = 0;
    logic [7:0] m_la = '0, m_ld = 8'hFF;

    function automatic bit m_inr(logic [7:0] a);
        return (a < 8'd64) || (a == CFG);
    endfunction
    function automatic bit m_valid(logic [7:0] a);
        return ((a < 8'd64) && !blk_prot[a / 16]) || (a == CFG);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_fail = 0; m_auto = 0; m_bad = 0; m_la = '0; m_ld = 8'hFF;
        end else begin
            bit ctlw;
            ctlw = cpu_wr && cpu_addr == CTL;
            case (m_mode)
                0: if (ctlw) begin
                    m_auto = cpu_wdata[4];
                    if (cpu_wdata[1]) m_mode = 1;
                end
                1: if (cpu_wr && m_valid(cpu_addr)) begin
                    m_la = cpu_addr; m_ld = cpu_wdata; m_mode = 2;
                end else if (cpu_rd && m_inr(cpu_addr)) m_la = cpu_addr;
                2: if (ctlw) begin
                    m_auto = cpu_wdata[4];
                    if (cpu_wdata[0] && cpu_wdata[3:2] == 2'b00 && m_valid(m_la)) begin
                        m_mode = 3; m_len = 0; m_bad = 0;
                    end else if (!cpu_wdata[1]) m_mode = 0;
                end else if (cpu_wr && m_valid(cpu_addr)) begin
                    m_la = cpu_addr; m_ld = cpu_wdata;
                end else if (cpu_rd && m_inr(cpu_addr)) m_la = cpu_addr;
                default: begin
                    bit ends;
                    m_len++;
                    if (cpu_rd && m_inr(cpu_addr)) m_bad = 1;
                    ends = 0;
                    if (m_auto && m_len == TA) ends = 1;
                    else if (ctlw && !cpu_wdata[0]) begin
                        ends = 1;
                        if (m_len < (m_auto ? TA : TP)) m_bad = 1;
                    end
                    if (ends) begin
                        if (m_bad) m_fail = 1;
                        else m_mem[m_la] = m_mem[m_la] & m_ld;
                        m_mode = 2;
                    end
                end
            endcase
        end
    end

    // R7 R10 per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            n_run++;
            if (hv_en !== (m_mode == 3) || prog_fail !== m_fail) begin
                n_fail++;
                $display("FAIL R7/R10 cycle model: hv_en=%0b fail=%0b expected hv_en=%0b fail=%0b",
                         hv_en, prog_fail, (m_mode == 3), m_fail);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #2 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wait_hv_low(output int n);
        n = 0;
        while (hv_en && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int n;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'hFF;
            m_mem[i] = 8'hFF;
        end
        mem[5] = 8'hF0; m_mem[5] = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;

        // R1 reset state
        chk("R1 hv_en", hv_en, 0);
        chk("R1 prog_fail", prog_fail, 0);
        bus_rd(CTL, rd); chk("R1 ctl", rd, 8'h00);

        // R2 array write with capture off
        bus_wr(8'd5, 8'h00);
        chk("R2 array untouched", mem[5], 8'hF0);

        // R6 program request with capture off
        bus_wr(CTL, 8'h01);
        chk("R6 no arm from idle", hv_en, 0);
        bus_rd(CTL, rd); chk("R6 ctl idle", rd, 8'h00);

        // R5 control writes ignored before capture; protected write not captured (R3)
        bus_wr(CTL, 8'h02);
        bus_wr(8'd20, 8'h00);
        bus_wr(CTL, 8'h03);
        chk("R5 arm ignored", hv_en, 0);
        bus_rd(CTL, rd); chk("R5 ctl unchanged", rd, 8'h02);

        // R3 last valid write wins; R7 manual program; R9 staged clear
        bus_wr(8'd7, 8'h00);
        bus_wr(8'd5, 8'h3C);
        bus_wr(CTL, 8'h03);
        chk("R7 hv_en on", hv_en, 1);
        bus_rd(CTL, rd); chk("R7 ctl busy", rd, 8'h03);
        repeat (70) @(negedge clk);
        bus_wr(CTL, 8'h00);
        chk("R9 hv_en off", hv_en, 0);
        bus_rd(CTL, rd); chk("R9 capture kept", rd, 8'h02);
        chk("R7 AND write-back", mem[5], 8'h30);
        chk("R3 earlier write dropped", mem[7], 8'hFF);

        // R4 read relatch, then R8 self-timed program
        bus_rd(8'd9, rd); chk("R4 read returns latch", rd, 8'h3C);
        bus_wr(CTL, 8'h13);
        wait_hv_low(n);
        chk("R8 self-timed length", n, TA);
        chk("R4 relatched target", mem[9], 8'h3C);
        chk("R4 old target kept", mem[5], 8'h30);

        // R6 erase bits set
        bus_wr(CTL, 8'h06);
        bus_wr(CTL, 8'h07);
        chk("R6 erase bits block", hv_en, 0);
        bus_rd(CTL, rd); chk("R6 ctl erase", rd, 8'h06);

        // R6 latched address protected after relatch
        bus_wr(CTL, 8'h02);
        bus_rd(8'd20, rd);
        bus_wr(CTL, 8'h03);
        chk("R6 protected latch blocks", hv_en, 0);

        // R12 back to idle, direct reads
        bus_wr(CTL, 8'h00);
        bus_rd(8'd5, rd); chk("R12 direct read", rd, 8'h30);
        bus_rd(CTL, rd); chk("R12 ctl idle", rd, 8'h00);

        // R3 config location with all blocks protected
        blk_prot = 4'b1111;
        bus_wr(CTL, 8'h12);
        bus_wr(CFG, 8'h5A);
        bus_wr(CTL, 8'h13);
        wait_hv_low(n);
        chk("R3 config programmed", mem[CFG], 8'h5A);

        // R10 read during programming
        blk_prot = 4'b0000;
        bus_wr(8'd3, 8'h00);
        bus_wr(CTL, 8'h13);
        bus_rd(8'd3, rd);
        wait_hv_low(n);
        chk("R10 prog_fail", prog_fail, 1);
        chk("R10 no write-back", mem[3], 8'hFF);
        bus_rd(CTL, rd); chk("R10 ctl fail bit", rd, 8'h92);

        // R11 short manual pulse
        do_reset();
        chk("R11 fail cleared by reset", prog_fail, 0);
        bus_wr(CTL, 8'h02);
        bus_wr(8'd4, 8'h00);
        bus_wr(CTL, 8'h03);
        repeat (10) @(negedge clk);
        bus_wr(CTL, 8'h02);
        chk("R11 hv_en off", hv_en, 0);
        chk("R11 prog_fail", prog_fail, 1);
        chk("R11 no write-back", mem[4], 8'hFF);

        // R7 whole array against model
        n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== m_mem[i]) n++;
        chk("R7 array matches model", n, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule